// File: doc/BRIEF.md
# Program Memory Read Stall Unit

This unit sits beside the decoder of a small single-issue microcontroller core. It lets running code fetch one word of its own program memory as data. Software first writes the word address into an address-low register and an address-high register. It then writes the control register with the space-select bit set to program memory and the read bit set. During the two instruction slots that follow that write, the unit drives the address to the memory array. It also replaces whatever the fetch stage delivers in those two slots with a no-operation word. The program counter outside the unit keeps counting through both slots, so execution carries on at the third word after the strobe. The word read from memory lands in a pair of data registers, and the read bit drops back to zero at that moment.

Interrupt requests pass through with no added latency, including during the stalled slots. If an interrupt is taken inside a stalled slot, the unit reports a return address that skips the words the stall would have discarded. The memory access still finishes into the data registers, and the rest of the stall is not applied to the interrupt vector's code. If the data-space select is chosen instead, the unit ignores the read strobe, because data EEPROM access is handled elsewhere.

Top module: `pmr_stall_unit`

## Requirements
- R1: After reset the busy flag, the space select, both data registers and the memory enable are 0, and the decoder word equals the fetched word.
- R2: A control-register write (wr_sel = 2) with bit 0 (read) and bit 7 (program space) both 1 starts a read. In the next cycle mem_en is 1 and mem_addr is {address-high[4:0], address-low}, taken from registers written with wr_sel 0 (low) and 1 (high).
- R3: The cycle of the strobe passes its fetched word. In the two cycles after it, dec_word is 14'h0000 whatever fetch_word holds, and from the third cycle the fetched word passes again.
- R4: From the cycle after the second stalled slot, data_lo holds word bits 7:0 and data_hi holds word bits 13:8, with data_hi bits 7:6 at 0.
- R5: rd_busy is 1 in exactly the two stalled slots and 0 from the cycle the data is visible.
- R6: With bit 7 of the control write at 0 (data space), the read bit has no effect: no stall, no mem_en, rd_busy stays 0 and the data registers keep their values.
- R7: irq_take equals irq_req in the same cycle, in stalled and normal slots alike.
- R8: irq_ret_pc is fetch_pc in a normal slot, fetch_pc+2 in the first stalled slot and fetch_pc+1 in the second, modulo 2^13.
- R9: After an interrupt is taken in the first stalled slot, the second slot's fetched word passes to the decoder unchanged, rd_busy stays 1 in that slot, and the read completes into the data registers on the usual cycle.
- R10: A control write while rd_busy is 1 is ignored, and a control write with the read bit 0 only updates space_prog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe from the executing instruction |
| wr_sel | input | 2 | Register select: 0 address low, 1 address high, 2 control |
| wr_data | input | 8 | Register write data |
| fetch_pc | input | 13 | Address of the word in the current slot |
| fetch_word | input | 14 | Word fetched for the current slot |
| irq_req | input | 1 | Gated interrupt request |
| mem_rdata | input | 14 | Program array read data, one cycle after mem_en |
| mem_en | output | 1 | Program array read enable |
| mem_addr | output | 13 | Program array read address |
| dec_word | output | 14 | Word handed to the decoder |
| irq_take | output | 1 | Interrupt accepted in this slot |
| irq_ret_pc | output | 13 | Return address to stack when irq_take is 1 |
| rd_busy | output | 1 | Read bit, 1 while the read is in progress |
| space_prog | output | 1 | Space select, 1 for program memory |
| data_lo | output | 8 | Read result, low byte |
| data_hi | output | 8 | Read result, high bits |

## Verification
The case of interest is an interrupt request that arrives in the same slot as a stalled read. In that slot the interrupt return path and the stall path both act. The bench raises irq_req in the first stalled slot, in the second stalled slot and in an ordinary slot, once with a program counter near the top of the address space so that the return address wraps. For each case it compares the return address, the decoder word in the following slot and the arrival of the read data against values worked out from the slot position.

// File: rtl/pmr_pkg.sv
`timescale 1ns/1ps
package pmr_pkg;

    localparam int WORD_W  = 14;
    localparam int PC_W    = 13;
    localparam int ADDR_W  = 13;
    localparam int BYTE_W  = 8;

    localparam int RD_BIT    = 0;
    localparam int SPACE_BIT = 7;

    typedef enum logic [1:0] {
        SEL_ADR_LO = 2'd0,
        SEL_ADR_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ADDR = 2'd1,
        SQ_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } data_pair_t;

    typedef struct packed {
        logic       mem_en;
        logic       load;
        logic       suppress;
        logic [1:0] slots_left;
    } seq_out_t;

    function automatic logic is_prog_strobe(logic we, logic [1:0] sel,
                                            logic [BYTE_W-1:0] d);
        return we && (sel == SEL_CTRL) && d[RD_BIT] && d[SPACE_BIT];
    endfunction

endpackage

// File: rtl/pmr_regfile.sv
`timescale 1ns/1ps
module pmr_regfile
    import pmr_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    input  logic [WW-1:0]     load_word,
    output logic              strobe,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              space,
    output data_pair_t        data
);
    localparam int HI_W = AW - BYTE_W;
    localparam int PAD  = 2 * BYTE_W - WW;

    logic [BYTE_W-1:0] adr_lo;
    logic [HI_W-1:0]   adr_hi;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL) && !busy;
    assign strobe  = !busy && is_prog_strobe(wr_en, wr_sel, wr_data);
    assign rd_addr = {adr_hi, adr_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_lo <= '0;
            adr_hi <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ADR_LO) adr_lo <= wr_data;
            if (wr_sel == SEL_ADR_HI) adr_hi <= wr_data[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            space <= 1'b0;
        end else begin
            if (ctrl_wr) space <= wr_data[SPACE_BIT];
            if (strobe)    busy <= 1'b1;
            else if (load) busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load) begin
            data <= {{PAD{1'b0}}, load_word};
        end
    end

endmodule

// File: rtl/pmr_sequencer.sv
`timescale 1ns/1ps
module pmr_sequencer
    import pmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     irq_take,
    output seq_out_t so
);
    seq_state_e state;
    logic       cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            cancel <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    cancel <= 1'b0;
                    if (start) state <= SQ_ADDR;
                end
                SQ_ADDR: begin
                    state  <= SQ_DATA;
                    cancel <= irq_take;
                end
                default: begin
                    state  <= SQ_IDLE;
                    cancel <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        so            = '0;
        so.mem_en     = (state == SQ_ADDR);
        so.load       = (state == SQ_DATA);
        so.suppress   = (state == SQ_ADDR) || ((state == SQ_DATA) && !cancel);
        if (state == SQ_ADDR)
            so.slots_left = 2'd2;
        else if ((state == SQ_DATA) && !cancel)
            so.slots_left = 2'd1;
        else
            so.slots_left = 2'd0;
    end

endmodule

// File: rtl/pmr_slot_mux.sv
`timescale 1ns/1ps
module pmr_slot_mux
    import pmr_pkg::*;
#(
    parameter int WW  = WORD_W,
    parameter int PCW = PC_W
) (
    input  logic [WW-1:0]  fetch_word,
    input  logic [PCW-1:0] fetch_pc,
    input  logic           irq_req,
    input  logic           suppress,
    input  logic [1:0]     slots_left,
    output logic [WW-1:0]  dec_word,
    output logic           irq_take,
    output logic [PCW-1:0] irq_ret_pc
);
    localparam logic [WW-1:0] NOP_WORD = '0;

    assign dec_word   = suppress ? NOP_WORD : fetch_word;
    assign irq_take   = irq_req;
    assign irq_ret_pc = fetch_pc + PCW'(slots_left);

endmodule

// File: rtl/pmr_stall_unit.sv
`timescale 1ns/1ps
module pmr_stall_unit
    import pmr_pkg::*;
#(
    parameter int WW  = WORD_W,
    parameter int PCW = PC_W,
    parameter int AW  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PCW-1:0]    fetch_pc,
    input  logic [WW-1:0]     fetch_word,
    input  logic              irq_req,
    input  logic [WW-1:0]     mem_rdata,
    output logic              mem_en,
    output logic [AW-1:0]     mem_addr,
    output logic [WW-1:0]     dec_word,
    output logic              irq_take,
    output logic [PCW-1:0]    irq_ret_pc,
    output logic              rd_busy,
    output logic              space_prog,
    output logic [BYTE_W-1:0] data_lo,
    output logic [BYTE_W-1:0] data_hi
);
    logic       strobe;
    seq_out_t   so;
    data_pair_t data;

    pmr_regfile #(.WW(WW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .load      (so.load),
        .load_word (mem_rdata),
        .strobe    (strobe),
        .rd_addr   (mem_addr),
        .busy      (rd_busy),
        .space     (space_prog),
        .data      (data)
    );

    pmr_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (strobe),
        .irq_take (irq_take),
        .so       (so)
    );

    pmr_slot_mux #(.WW(WW), .PCW(PCW)) u_mux (
        .fetch_word (fetch_word),
        .fetch_pc   (fetch_pc),
        .irq_req    (irq_req),
        .suppress   (so.suppress),
        .slots_left (so.slots_left),
        .dec_word   (dec_word),
        .irq_take   (irq_take),
        .irq_ret_pc (irq_ret_pc)
    );

    assign mem_en  = so.mem_en;
    assign data_lo = data.lo;
    assign data_hi = data.hi;

endmodule

// File: rtl/pmr_stall_unit_chk.sv
`timescale 1ns/1ps
module pmr_stall_unit_chk #(
    parameter int WW  = 14,
    parameter int PCW = 13
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_busy,
    input logic           mem_en,
    input logic           space_prog,
    input logic [WW-1:0]  dec_word,
    input logic [WW-1:0]  mem_rdata,
    input logic [7:0]     data_lo,
    input logic [7:0]     data_hi,
    input logic           irq_take,
    input logic [PCW-1:0] fetch_pc,
    input logic [PCW-1:0] irq_ret_pc
);
    localparam int PAD = 16 - WW;

    // R3
    first_slot_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> (dec_word == '0));

    // R2
    first_slot_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> mem_en);

    // R5
    busy_two_slots_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_busy) |-> $past(rd_busy, 2));

    // R4
    data_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_busy) |-> ({data_hi, data_lo} == {{PAD{1'b0}}, $past(mem_rdata)}));

    // R6
    prog_space_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> space_prog);

    // R8
    plain_return_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !rd_busy) |-> (irq_ret_pc == fetch_pc));

endmodule

bind pmr_stall_unit pmr_stall_unit_chk #(.WW(WW), .PCW(PCW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_busy    (rd_busy),
    .mem_en     (mem_en),
    .space_prog (space_prog),
    .dec_word   (dec_word),
    .mem_rdata  (mem_rdata),
    .data_lo    (data_lo),
    .data_hi    (data_hi),
    .irq_take   (irq_take),
    .fetch_pc   (fetch_pc),
    .irq_ret_pc (irq_ret_pc)
);

// File: tb/pmr_stall_unit_test.sv
`timescale 1ns/1ps
module pmr_stall_unit_test;

    localparam int ID_DEC   = 0;
    localparam int ID_TAKE  = 1;
    localparam int ID_RET   = 2;
    localparam int ID_BUSY  = 3;
    localparam int ID_LO    = 4;
    localparam int ID_HI    = 5;
    localparam int ID_MEMEN = 6;
    localparam int ID_ADDR  = 7;
    localparam int ID_SPACE = 8;

    typedef struct {
        int          id;
        logic [15:0] exp;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [7:0]  wr_data = 8'h00;
    logic [12:0] fetch_pc = '0;
    logic [13:0] fetch_word = '0;
    logic        irq_req = 1'b0;
    logic [13:0] mem_rdata = '0;
    logic        mem_en;
    logic [12:0] mem_addr;
    logic [13:0] dec_word;
    logic        irq_take;
    logic [12:0] irq_ret_pc;
    logic        rd_busy;
    logic        space_prog;
    logic [7:0]  data_lo;
    logic [7:0]  data_hi;

    exp_item_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmr_stall_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fetch_pc(fetch_pc), .fetch_word(fetch_word), .irq_req(irq_req),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_addr(mem_addr),
        .dec_word(dec_word), .irq_take(irq_take), .irq_ret_pc(irq_ret_pc),
        .rd_busy(rd_busy), .space_prog(space_prog), .data_lo(data_lo),
        .data_hi(data_hi)
    );

    function automatic logic [13:0] prog_word(logic [12:0] a);
        logic [31:0] t;
        t = (32'(a) * 32'd37) ^ 32'h2A5;
        return t[13:0];
    endfunction

    // program array model: synchronous read
    always @(posedge clk) begin
        if (mem_en) mem_rdata <= prog_word(mem_addr);
    end

    function automatic logic [15:0] pick(int id);
        case (id)
            ID_DEC:   return {2'b00, dec_word};
            ID_TAKE:  return {15'd0, irq_take};
            ID_RET:   return {3'b000, irq_ret_pc};
            ID_BUSY:  return {15'd0, rd_busy};
            ID_LO:    return {8'h00, data_lo};
            ID_HI:    return {8'h00, data_hi};
            ID_MEMEN: return {15'd0, mem_en};
            ID_ADDR:  return {3'b000, mem_addr};
            default:  return {15'd0, space_prog};
        endcase
    endfunction

    // monitor: compares expectations of each cycle before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [15:0] act;
                it  = exp_q.pop_front();
                act = pick(it.id);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: signal %0d actual %h expected %h at %0t",
                             it.req, it.id, act, it.exp, $time);
                end
            end
        end
    end

    task automatic drive(bit we, logic [1:0] sel, logic [7:0] d,
                         logic [12:0] pc, logic [13:0] w, bit irq);
        @(negedge clk);
        wr_en      = we;
        wr_sel     = sel;
        wr_data    = d;
        fetch_pc   = pc;
        fetch_word = w;
        irq_req    = irq;
    endtask

    task automatic expect_v(int id, logic [15:0] v, string r);
        exp_item_t it;
        it.id  = id;
        it.exp = v;
        it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic expect_data(logic [13:0] w, string r);
        expect_v(ID_LO, {8'h00, w[7:0]}, r);
        expect_v(ID_HI, {10'd0, w[13:8]}, r);
    endtask

    initial begin
        logic [13:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        drive(0, 2'd3, 8'h00, 13'd10, 14'h1ABC, 0);
        expect_v(ID_DEC, 16'h1ABC, "R1");
        expect_v(ID_BUSY, 16'd0, "R1");
        expect_v(ID_LO, 16'd0, "R1");
        expect_v(ID_HI, 16'd0, "R1");
        expect_v(ID_SPACE, 16'd0, "R1");
        expect_v(ID_MEMEN, 16'd0, "R1");

        // address 0x1234, then space select alone (R10)
        drive(1, 2'd0, 8'h34, 13'd11, 14'h0000, 0);
        drive(1, 2'd1, 8'h12, 13'd12, 14'h0000, 0);
        drive(1, 2'd2, 8'h80, 13'd13, 14'h0000, 0);
        drive(0, 2'd3, 8'h00, 13'd14, 14'h0042, 0);
        expect_v(ID_SPACE, 16'd1, "R10");
        expect_v(ID_BUSY, 16'd0, "R10");
        expect_v(ID_MEMEN, 16'd0, "R10");
        expect_v(ID_DEC, 16'h0042, "R10");

        // plain read
        w = prog_word(13'h1234);
        drive(1, 2'd2, 8'h81, 13'd20, 14'h0111, 0);
        expect_v(ID_DEC, 16'h0111, "R3");
        expect_v(ID_BUSY, 16'd0, "R5");
        drive(0, 2'd3, 8'h00, 13'd21, 14'h3FFF, 0);
        expect_v(ID_DEC, 16'h0000, "R3");
        expect_v(ID_MEMEN, 16'd1, "R2");
        expect_v(ID_ADDR, 16'h1234, "R2");
        expect_v(ID_BUSY, 16'd1, "R5");
        drive(1, 2'd2, 8'h00, 13'd22, 14'h1555, 0);
        expect_v(ID_DEC, 16'h0000, "R3");
        expect_v(ID_BUSY, 16'd1, "R5");
        expect_v(ID_MEMEN, 16'd0, "R2");
        drive(0, 2'd3, 8'h00, 13'd23, 14'h0ABC, 0);
        expect_v(ID_DEC, 16'h0ABC, "R3");
        expect_v(ID_BUSY, 16'd0, "R5");
        expect_data(w, "R4");
        expect_v(ID_SPACE, 16'd1, "R10");

        // interrupt in the first stalled slot
        drive(1, 2'd0, 8'h07, 13'd99, 14'h0000, 0);
        w = prog_word(13'h1207);
        drive(1, 2'd2, 8'h81, 13'd100, 14'h0123, 0);
        drive(0, 2'd3, 8'h00, 13'd101, 14'h2000, 1);
        expect_v(ID_TAKE, 16'd1, "R7");
        expect_v(ID_RET, 16'd103, "R8");
        expect_v(ID_DEC, 16'h0000, "R3");
        drive(0, 2'd3, 8'h00, 13'd4, 14'h2222, 0);
        expect_v(ID_DEC, 16'h2222, "R9");
        expect_v(ID_BUSY, 16'd1, "R9");
        expect_v(ID_TAKE, 16'd0, "R7");
        drive(0, 2'd3, 8'h00, 13'd5, 14'h0333, 0);
        expect_data(w, "R9");
        expect_v(ID_BUSY, 16'd0, "R9");
        expect_v(ID_DEC, 16'h0333, "R9");

        // interrupt in the second stalled slot
        drive(1, 2'd0, 8'h55, 13'd199, 14'h0000, 0);
        w = prog_word(13'h1255);
        drive(1, 2'd2, 8'h81, 13'd200, 14'h0000, 0);
        drive(0, 2'd3, 8'h00, 13'd201, 14'h0FFF, 0);
        expect_v(ID_ADDR, 16'h1255, "R2");
        drive(0, 2'd3, 8'h00, 13'd202, 14'h0EEE, 1);
        expect_v(ID_TAKE, 16'd1, "R7");
        expect_v(ID_RET, 16'd203, "R8");
        expect_v(ID_DEC, 16'h0000, "R3");
        drive(0, 2'd3, 8'h00, 13'd4, 14'h0444, 0);
        expect_data(w, "R4");
        expect_v(ID_DEC, 16'h0444, "R3");

        // interrupt in a normal slot
        drive(0, 2'd3, 8'h00, 13'd300, 14'h0555, 1);
        expect_v(ID_TAKE, 16'd1, "R7");
        expect_v(ID_RET, 16'd300, "R8");
        expect_v(ID_DEC, 16'h0555, "R8");

        // data space: read bit has no effect (R6)
        drive(1, 2'd2, 8'h01, 13'd301, 14'h0666, 0);
        drive(0, 2'd3, 8'h00, 13'd302, 14'h0777, 0);
        expect_v(ID_SPACE, 16'd0, "R6");
        expect_v(ID_BUSY, 16'd0, "R6");
        expect_v(ID_MEMEN, 16'd0, "R6");
        expect_v(ID_DEC, 16'h0777, "R6");
        drive(0, 2'd3, 8'h00, 13'd303, 14'h0888, 0);
        expect_v(ID_DEC, 16'h0888, "R6");
        drive(0, 2'd3, 8'h00, 13'd304, 14'h0999, 0);
        expect_data(w, "R6");

        // top of address space and return-address wrap
        drive(1, 2'd0, 8'hFF, 13'd305, 14'h0000, 0);
        drive(1, 2'd1, 8'hFF, 13'd306, 14'h0000, 0);
        drive(1, 2'd2, 8'h80, 13'd307, 14'h0000, 0);
        w = prog_word(13'h1FFF);
        drive(1, 2'd2, 8'h81, 13'h1FFE, 14'h0000, 0);
        drive(0, 2'd3, 8'h00, 13'h1FFF, 14'h3ABC, 1);
        expect_v(ID_ADDR, 16'h1FFF, "R2");
        expect_v(ID_RET, 16'h0001, "R8");
        drive(0, 2'd3, 8'h00, 13'd4, 14'h3DEF, 0);
        expect_v(ID_DEC, 16'h3DEF, "R9");
        drive(0, 2'd3, 8'h00, 13'd5, 14'h0000, 0);
        expect_data(w, "R4");

        drive(0, 2'd3, 8'h00, 13'd6, 14'h0000, 0);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

endmodule